// File: doc/BRIEF.md
# Watchdog Clock Source Selector

This block picks the tick that advances a watchdog counter and decides whether that tick may pass while the chip is stopped. Each clock source reaches it as a one-cycle enable in the system clock domain. There are three sources: an auxiliary tick from a trimmable internal RC oscillator, a tick from the internal reference clock, and a tick from the crystal oscillator. A small configuration word chooses among them. That word holds a main select, a sub select, an auxiliary-in-stop disable and a pseudo-stop run enable. It is written through a single write strobe and is cleared to zero at reset, so the reference tick is the default source.

Some configuration writes change the effective source. For those the block emits a registered one-cycle restart pulse, which tells the watchdog counter to begin a new timeout period. The block also sequences stop entry. When the auxiliary clock is selected and is disabled in stop, entry waits for two auxiliary ticks, which stand for the synchronization latency. After the matching stop exit, a guard of two auxiliary ticks must pass before a new entry is accepted. A request that arrives inside the guard is reported as a protocol error and dropped. While stopped, a source-dependent gate decides whether the watchdog freezes. A frozen watchdog keeps its count, because this block never resets it.

Top module: `wdog_clk_sel`

## Requirements
- R1: After reset the configuration is all zero and wdTick, restartPulse, stopReady and protocolErr are 0. With that configuration a refTick pulse appears on wdTick one cycle later.
- R2: With the main select at 1, wdTick is 1 in the cycle after an auxTick pulse. With the main select at 1, refTick, oscTick and the sub select have no effect on wdTick.
- R3: With the main select at 0, sub select 0 routes refTick to wdTick and sub select 1 routes oscTick to wdTick, each one cycle later.
- R4: oscTick reaches wdTick only while oscUp is 1. oscUp never alters the stored main select.
- R5: A write that changes the main select makes restartPulse 1 for exactly the one cycle after the write.
- R6: A write that flips the sub select while the main select is 0 both before and after the write pulses restartPulse. No restart pulse follows a write that flips the sub select while the main select is 1 both before and after. No restart pulse follows a write that changes only the auxiliary-in-stop disable or the pseudo-stop enable.
- R7: In fast entry, a rising stopReq makes stopReady 1 one cycle later. Fast entry is any case that is not (main select 1 and auxiliary-in-stop disable 1). stopReady drops one cycle after stopReq falls.
- R8: In slow entry (main select 1 and auxiliary-in-stop disable 1 when stopReq rises), stopReady rises one cycle after the second auxTick seen after the request.
- R9: After a slow-entry stop ends, a stopReq rise before two auxTick pulses have occurred gives protocolErr for one cycle and does not enter stop, even if stopReq is held. A fresh rise after the guard enters normally.
- R10: While stopReady is 1, the gate depends on the source. The reference source never ticks. The auxiliary source ticks only if its stop disable is 0. The oscillator source ticks only if pseudoStop and the pseudo-stop enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMainSel | input | 1 | Main select: 1 = auxiliary RC tick |
| cfgSubSel | input | 1 | Sub select when main is 0: 0 = reference, 1 = oscillator |
| cfgAuxStopDis | input | 1 | 1 = auxiliary tick blocked in stop (slow entry) |
| cfgPseudoRun | input | 1 | 1 = oscillator source keeps ticking in pseudo stop |
| auxTick | input | 1 | Auxiliary RC clock enable |
| refTick | input | 1 | Internal reference clock enable |
| oscTick | input | 1 | Oscillator clock enable |
| oscUp | input | 1 | Oscillator running and stable |
| pseudoStop | input | 1 | 1 = stop keeps the oscillator running |
| stopReq | input | 1 | Level request to be in stop |
| wdTick | output | 1 | Registered watchdog advance enable |
| restartPulse | output | 1 | One-cycle timeout restart |
| stopReady | output | 1 | Stop has been entered |
| protocolErr | output | 1 | One-cycle pulse: stop request inside the exit guard |

## Verification
The bench writes the sub select with the main select held at 1 and expects no restart. A design that compared every select bit would raise a spurious restart there. It counts auxiliary ticks one at a time during slow entry, which exposes a design that enters stop on the first tick or ignores the latency. It raises stopReq inside the exit guard and holds it through the end of the guard, so a design that queued the request or used level sensing instead of edge sensing would enter stop wrongly. It also covers the three sources under stop gating, so a design that let the reference tick through, or ignored the pseudo-stop enable, would put a tick on wdTick.

// File: rtl/wdog_clk_sel_pkg.sv
package wdog_clk_sel_pkg;

  typedef struct packed {
    logic mainSel;
    logic subSel;
    logic auxStopDis;
    logic pseudoRun;
  } selCfg_t;

  typedef struct packed {
    logic inStop;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_STOP  = 2'd2,
    ST_GUARD = 2'd3
  } stopState_e;

endpackage

// File: rtl/wdog_clk_sel_datapath.sv
module wdog_clk_sel_datapath
  import wdog_clk_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  selCfg_t     cfgIn,
  input  logic        auxTick,
  input  logic        refTick,
  input  logic        oscTick,
  input  logic        oscUp,
  input  logic        pseudoStop,
  input  ctrlStrobe_t strobe,
  output logic        slowStop,
  output logic        wdTick,
  output logic        restartPulse
);

  selCfg_t cfgQ;
  logic    srcTick;
  logic    stopPass;
  logic    mainFlip;
  logic    subFlip;

  // configuration word, cleared so the reference tick is the default
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgIn;
  end

  // restart on a main flip, or on a sub flip while main stays low
  always_comb begin
    mainFlip = cfgWe && (cfgIn.mainSel != cfgQ.mainSel);
    subFlip  = cfgWe && !cfgQ.mainSel && !cfgIn.mainSel &&
               (cfgIn.subSel != cfgQ.subSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) restartPulse <= 1'b0;
    else       restartPulse <= mainFlip || subFlip;
  end

  // source mux and stop gate
  always_comb begin
    if (cfgQ.mainSel) begin
      srcTick  = auxTick;
      stopPass = !cfgQ.auxStopDis;
    end else if (cfgQ.subSel) begin
      srcTick  = oscTick && oscUp;
      stopPass = pseudoStop && cfgQ.pseudoRun;
    end else begin
      srcTick  = refTick;
      stopPass = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdTick <= 1'b0;
    else       wdTick <= srcTick && (!strobe.inStop || stopPass);
  end

  assign slowStop = cfgQ.mainSel && cfgQ.auxStopDis;

  // R5: a restart can only follow a configuration write
  p_restart_from_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> $past(cfgWe));

  // R2: every watchdog tick comes from some source tick
  p_tick_has_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    wdTick |-> $past(auxTick || refTick || oscTick));

  // R10: reference source is silent in stop
  p_ref_quiet_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.inStop) && $past(!cfgQ.mainSel && !cfgQ.subSel)) |-> !wdTick);

endmodule

// File: rtl/wdog_clk_sel_control.sv
module wdog_clk_sel_control
  import wdog_clk_sel_pkg::*;
#(
  parameter int SYNC_TICKS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopReq,
  input  logic        auxTick,
  input  logic        slowStop,
  output ctrlStrobe_t strobe,
  output logic        stopReady,
  output logic        protocolErr
);

  localparam int CNT_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SYNC_TICKS - 1);

  stopState_e state, stateNext;
  logic [CNT_W-1:0] auxCnt, auxCntNext;
  logic reqQ;
  logic reqRise;
  logic slowQ;

  assign reqRise = stopReq && !reqQ;

  always_comb begin
    stateNext  = state;
    auxCntNext = auxCnt;
    unique case (state)
      ST_RUN: begin
        auxCntNext = '0;
        if (reqRise) stateNext = slowStop ? ST_ENTER : ST_STOP;
      end
      ST_ENTER: begin
        if (!stopReq) begin
          stateNext  = ST_RUN;
          auxCntNext = '0;
        end else if (auxTick) begin
          if (auxCnt == LAST_CNT) begin
            stateNext  = ST_STOP;
            auxCntNext = '0;
          end else begin
            auxCntNext = auxCnt + 1'b1;
          end
        end
      end
      ST_STOP: begin
        auxCntNext = '0;
        if (!stopReq) stateNext = slowQ ? ST_GUARD : ST_RUN;
      end
      ST_GUARD: begin
        if (auxTick) begin
          if (auxCnt == LAST_CNT) begin
            stateNext  = ST_RUN;
            auxCntNext = '0;
          end else begin
            auxCntNext = auxCnt + 1'b1;
          end
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_RUN;
      auxCnt      <= '0;
      reqQ        <= 1'b0;
      slowQ       <= 1'b0;
      protocolErr <= 1'b0;
    end else begin
      state       <= stateNext;
      auxCnt      <= auxCntNext;
      reqQ        <= stopReq;
      protocolErr <= (state == ST_GUARD) && reqRise;
      if (state == ST_RUN && reqRise) slowQ <= slowStop;
    end
  end

  assign stopReady     = (state == ST_STOP);
  assign strobe.inStop = (state == ST_STOP);

  // R8: slow entry completes only on an auxiliary tick
  p_entry_on_aux_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stopReady) && slowQ) |-> $past(auxTick));

  // R9: a flagged request never coincides with stop
  p_err_not_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    protocolErr |-> !stopReady);

  // R7: stop is only held while requested
  p_ready_needs_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopReady |-> $past(stopReq));

endmodule

// File: rtl/wdog_clk_sel.sv
module wdog_clk_sel
  import wdog_clk_sel_pkg::*;
#(
  parameter int SYNC_TICKS = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  logic cfgMainSel,
  input  logic cfgSubSel,
  input  logic cfgAuxStopDis,
  input  logic cfgPseudoRun,
  input  logic auxTick,
  input  logic refTick,
  input  logic oscTick,
  input  logic oscUp,
  input  logic pseudoStop,
  input  logic stopReq,
  output logic wdTick,
  output logic restartPulse,
  output logic stopReady,
  output logic protocolErr
);

  selCfg_t     cfgIn;
  ctrlStrobe_t strobe;
  logic        slowStop;

  assign cfgIn = '{mainSel: cfgMainSel, subSel: cfgSubSel,
                   auxStopDis: cfgAuxStopDis, pseudoRun: cfgPseudoRun};

  wdog_clk_sel_datapath u_datapath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .auxTick(auxTick), .refTick(refTick), .oscTick(oscTick),
    .oscUp(oscUp), .pseudoStop(pseudoStop), .strobe(strobe),
    .slowStop(slowStop), .wdTick(wdTick), .restartPulse(restartPulse)
  );

  wdog_clk_sel_control #(.SYNC_TICKS(SYNC_TICKS)) u_control (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .auxTick(auxTick),
    .slowStop(slowStop), .strobe(strobe), .stopReady(stopReady),
    .protocolErr(protocolErr)
  );

endmodule

// File: tb/wdog_clk_sel_bench.sv
`timescale 1ns/1ps
module wdog_clk_sel_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgMainSel = 0, cfgSubSel = 0, cfgAuxStopDis = 0, cfgPseudoRun = 0;
  logic auxTick = 0, refTick = 0, oscTick = 0, oscUp = 1, pseudoStop = 0, stopReq = 0;
  logic wdTick, restartPulse, stopReady, protocolErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_clk_sel u_wdog_clk_sel (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMainSel(cfgMainSel),
    .cfgSubSel(cfgSubSel), .cfgAuxStopDis(cfgAuxStopDis),
    .cfgPseudoRun(cfgPseudoRun), .auxTick(auxTick), .refTick(refTick),
    .oscTick(oscTick), .oscUp(oscUp), .pseudoStop(pseudoStop),
    .stopReq(stopReq), .wdTick(wdTick), .restartPulse(restartPulse),
    .stopReady(stopReady), .protocolErr(protocolErr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // write config; returns restartPulse seen in the cycle after
  task automatic wrCfg(input logic m, input logic s, input logic d, input logic e,
                       output logic rs);
    @(negedge clk);
    cfgWe = 1; cfgMainSel = m; cfgSubSel = s; cfgAuxStopDis = d; cfgPseudoRun = e;
    @(negedge clk);
    cfgWe = 0;
    rs = restartPulse;
    @(negedge clk);
    chk("R5 pulse lasts one cycle", restartPulse, 1'b0);
  endtask

  // pulse the three sources; return wdTick one cycle later
  task automatic pulse(input logic a, input logic r, input logic o, output logic t);
    @(negedge clk);
    auxTick = a; refTick = r; oscTick = o;
    @(negedge clk);
    auxTick = 0; refTick = 0; oscTick = 0;
    t = wdTick;
  endtask

  task automatic t_reset();
    logic t;
    chk("R1 wdTick reset", wdTick, 1'b0);
    chk("R1 restart reset", restartPulse, 1'b0);
    chk("R1 stopReady reset", stopReady, 1'b0);
    chk("R1 protocolErr reset", protocolErr, 1'b0);
    pulse(0, 1, 0, t); chk("R1 ref default source", t, 1'b1);
    pulse(1, 0, 1, t); chk("R1 aux/osc blocked by default", t, 1'b0);
  endtask

  task automatic t_sources();
    logic t, rs;
    wrCfg(0, 1, 0, 0, rs); chk("R6 sub flip with main 0 restarts", rs, 1'b1);
    pulse(0, 0, 1, t); chk("R3 osc routed", t, 1'b1);
    pulse(0, 1, 0, t); chk("R3 ref blocked on osc", t, 1'b0);
    oscUp = 0;
    pulse(0, 0, 1, t); chk("R4 osc blocked when oscUp 0", t, 1'b0);
    oscUp = 1;
    wrCfg(1, 1, 0, 0, rs); chk("R5 main flip restarts", rs, 1'b1);
    pulse(1, 0, 0, t); chk("R2 aux routed", t, 1'b1);
    pulse(0, 1, 1, t); chk("R2 ref/osc ignored on aux", t, 1'b0);
    wrCfg(1, 0, 0, 0, rs); chk("R6 sub flip with main 1 no restart", rs, 1'b0);
    pulse(0, 1, 1, t); chk("R2 sub select ignored", t, 1'b0);
    oscUp = 0; idle(3);
    pulse(1, 0, 0, t); chk("R4 main select kept when oscUp 0", t, 1'b1);
    oscUp = 1;
    wrCfg(1, 0, 1, 1, rs); chk("R6 stop-disable/pseudo change no restart", rs, 1'b0);
    wrCfg(0, 0, 0, 0, rs); chk("R5 main 1->0 restarts", rs, 1'b1);
  endtask

  task automatic t_fast_stop();
    logic t, rs;
    @(negedge clk); stopReq = 1;
    @(negedge clk); chk("R7 fast entry next cycle", stopReady, 1'b1);
    pulse(0, 1, 0, t); chk("R10 ref silent in stop", t, 1'b0);
    @(negedge clk); stopReq = 0;
    @(negedge clk); chk("R7 exit next cycle", stopReady, 1'b0);
    // oscillator source in pseudo stop
    wrCfg(0, 1, 0, 1, rs);
    pseudoStop = 1;
    @(negedge clk); stopReq = 1;
    @(negedge clk); chk("R7 fast entry osc", stopReady, 1'b1);
    pulse(0, 0, 1, t); chk("R10 osc runs in pseudo stop", t, 1'b1);
    pseudoStop = 0;
    pulse(0, 0, 1, t); chk("R10 osc frozen in full stop", t, 1'b0);
    @(negedge clk); stopReq = 0; idle(2);
    wrCfg(0, 1, 0, 0, rs);
    pseudoStop = 1;
    @(negedge clk); stopReq = 1; idle(1);
    pulse(0, 0, 1, t); chk("R10 osc frozen without pseudo enable", t, 1'b0);
    @(negedge clk); stopReq = 0; pseudoStop = 0; idle(2);
    // auxiliary source, running in stop
    wrCfg(1, 0, 0, 0, rs);
    @(negedge clk); stopReq = 1;
    @(negedge clk); chk("R7 fast entry aux enabled", stopReady, 1'b1);
    pulse(1, 0, 0, t); chk("R10 aux runs in stop", t, 1'b1);
    @(negedge clk); stopReq = 0; idle(2);
    chk("R7 no guard after fast exit", protocolErr, 1'b0);
  endtask

  task automatic t_slow_stop();
    logic t, rs;
    wrCfg(1, 0, 1, 0, rs);
    @(negedge clk); stopReq = 1;
    @(negedge clk); chk("R8 not ready before aux ticks", stopReady, 1'b0);
    auxTick = 1;
    @(negedge clk); chk("R8 not ready after one aux tick", stopReady, 1'b0);
    @(negedge clk); auxTick = 0;
    chk("R8 ready after second aux tick", stopReady, 1'b1);
    pulse(1, 0, 0, t); chk("R10 aux gated in stop", t, 1'b0);
    @(negedge clk); stopReq = 0;
    @(negedge clk); chk("R7 slow exit", stopReady, 1'b0);
    stopReq = 1;
    @(negedge clk); chk("R9 early request flagged", protocolErr, 1'b1);
    chk("R9 early request not entered", stopReady, 1'b0);
    @(negedge clk); chk("R9 error is one cycle", protocolErr, 1'b0);
    auxTick = 1; idle(2); auxTick = 0; idle(3);
    chk("R9 held request stays ignored", stopReady, 1'b0);
    stopReq = 0; idle(1);
    stopReq = 1; idle(1);
    chk("R9 no error after guard", protocolErr, 1'b0);
    auxTick = 1; idle(2); auxTick = 0;
    chk("R9 fresh request enters after guard", stopReady, 1'b1);
    stopReq = 0; idle(1);
    auxTick = 1; idle(2); auxTick = 0; idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_sources();
    t_fast_stop();
    t_slow_stop();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule